// File: doc/BRIEF.md
# Microprogram Sequencer Controller

This block steps through a microprogram held in an on-chip program memory of 512 words, each 36 bits wide. Every word does two things. It places a 16-bit pattern on the user outputs through a pipeline register, and it picks the next address. The next address is either the following word, a branch target, a counted-loop target, a return address popped from a bounded stack, or a multiway target that folds low test-input bits into the address. Eight test inputs feed a condition selector. A parameter mask decides, for each test input, whether it passes through a register stage first.

The program is written through a simple write port (enable, address, data), normally while reset is held. After reset is released, the sequencer fetches word 0 and runs freely. Two sticky flags report a call that found the stack full and a return that found it empty.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous reset sets the PC, count register, stack level, both flags and the user outputs to zero. On the first clock after reset is released, the word at address 0 is fetched and the PC stays 0. That word executes on the following clock.
- R2: Word fields are: opcode [35:32], condition select [31:28], polarity [27], target or count value [24:16], user outputs [15:0]. Opcode 0 (and any opcode from 7 to 15) moves the PC to PC+1, and 511 wraps to 0.
- R3: The condition is test input `sel` for select values 0 to 7, or constant true for 8 to 15. It is inverted when polarity is 1. Opcode 1 loads the target when the condition holds, and moves to PC+1 otherwise.
- R4: A test input whose bit is set in `TEST_REG_MASK` reaches the condition selector and the multiway logic one clock late. The other test inputs are used in the same cycle.
- R5: Opcode 4 loads the count register from the target field and moves to PC+1. Opcode 5 decrements a nonzero count and branches to the target. With a count of zero it moves to PC+1.
- R6: Opcode 2 branches when the condition holds and pushes PC+1. Opcode 3 pops the return address into the PC when the condition holds. The stack holds at most `STACK_DEPTH` entries (0 to 17) and works last-in first-out.
- R7: A taken call with a full stack still branches, but it stores nothing and sets the sticky overflow flag. The flag only rises after a call.
- R8: A taken return with an empty stack loads address 0 and sets the sticky underflow flag.
- R9: Opcode 6 loads the target OR'ed with the low three conditioned test inputs into bits [2:0].
- R10: The user outputs show the [15:0] field of the word executed on the previous clock, one cycle behind the PC.
- R11: A write on the load port stores the data at the given address, and a later fetch of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| test_in | input | 8 | Test inputs for conditions and multiway branches |
| load_en | input | 1 | Program memory write enable |
| load_addr | input | 9 | Program memory write address |
| load_data | input | 36 | Program memory write data |
| user_out | output | 16 | Pipelined user output pattern |
| pc | output | 9 | Address of the word now executing |
| stack_ovf | output | 1 | Sticky flag: call found the stack full |
| stack_unf | output | 1 | Sticky flag: return found the stack empty |

## Verification
The assertions assume the load port is only used while reset is held, or on addresses the running program does not fetch. Without that, the output-lag property would compare against a word that was replaced while it was being fetched. The stimulus writes the whole memory under reset, including every word the program never reaches, so no fetch returns an unwritten word. It then releases reset and leaves the port idle. The test inputs change only between clock edges and follow a pseudo-random sequence, so every condition and multiway branch is taken and not taken over the run.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int unsigned ADDR_W = 9;
    localparam int unsigned WORD_W = 36;
    localparam int unsigned OUT_W  = 16;
    localparam int unsigned TEST_W = 8;

    localparam int unsigned OPC_MSB = 35;
    localparam int unsigned OPC_LSB = 32;
    localparam int unsigned SEL_MSB = 31;
    localparam int unsigned SEL_LSB = 28;
    localparam int unsigned POL_BIT = 27;
    localparam int unsigned TGT_MSB = 24;
    localparam int unsigned TGT_LSB = 16;

    localparam logic [3:0] OP_CONT = 4'd0;
    localparam logic [3:0] OP_JUMP = 4'd1;
    localparam logic [3:0] OP_CALL = 4'd2;
    localparam logic [3:0] OP_RET  = 4'd3;
    localparam logic [3:0] OP_LDCT = 4'd4;
    localparam logic [3:0] OP_LOOP = 4'd5;
    localparam logic [3:0] OP_MWAY = 4'd6;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] cnt;
        logic              started;
        logic              ovf;
        logic              unf;
        logic [OUT_W-1:0]  out;
    } seq_state_t;

endpackage

// File: rtl/useq_progmem.sv
module useq_progmem #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 36
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Read returns the old contents on a same-address write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/useq_cond_sel.sv
module useq_cond_sel #(
    parameter int unsigned   NUM  = 8,
    parameter logic [NUM-1:0] MASK = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] raw,
    input  logic [3:0]     sel,
    input  logic           pol,
    output logic [NUM-1:0] tests_c,
    output logic           cond
);
    for (genvar g = 0; g < NUM; g++) begin : g_in
        if (MASK[g]) begin : g_reg
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else begin
                    bit_q <= raw[g];
                end
            end
            assign tests_c[g] = bit_q;
        end else begin : g_pass
            assign tests_c[g] = raw[g];
        end
    end

    logic hit;
    always_comb begin
        hit  = sel[3] ? 1'b1 : tests_c[sel[2:0]];
        cond = hit ^ pol;
    end
endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
    parameter int unsigned DEPTH = 17,
    parameter int unsigned W     = 9,
    parameter int unsigned LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     push_data,
    output logic [W-1:0]     top,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    if (DEPTH == 0) begin : g_none
        logic unused_stack_in;
        assign unused_stack_in = ^{clk, rst, push, pop, push_data};
        assign top   = '0;
        assign full  = 1'b1;
        assign empty = 1'b1;
        assign level = '0;
    end else begin : g_shift
        localparam int D = int'(DEPTH);

        logic [W-1:0]     ent_q [D];
        logic [W-1:0]     ent_d [D];
        logic [LVL_W-1:0] lvl_q;
        logic [LVL_W-1:0] lvl_d;
        logic             full_w;
        logic             empty_w;

        assign full_w  = (lvl_q == LVL_W'(DEPTH));
        assign empty_w = (lvl_q == '0);

        // Entry 0 is always the top; pushes and pops shift the whole column.
        always_comb begin
            ent_d = ent_q;
            lvl_d = lvl_q;
            if (push && !full_w) begin
                lvl_d    = lvl_q + 1'b1;
                ent_d[0] = push_data;
                for (int i = 1; i < D; i++) begin
                    ent_d[i] = ent_q[i-1];
                end
            end else if (pop && !empty_w) begin
                lvl_d = lvl_q - 1'b1;
                for (int i = 0; i < D - 1; i++) begin
                    ent_d[i] = ent_q[i+1];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q <= '0;
            end else begin
                lvl_q <= lvl_d;
            end
            ent_q <= ent_d;
        end

        assign top   = ent_q[0];
        assign full  = full_w;
        assign empty = empty_w;
        assign level = lvl_q;
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int unsigned STACK_DEPTH   = 17,
    parameter logic [7:0]  TEST_REG_MASK = 8'h0F
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  test_in,
    input  logic        load_en,
    input  logic [8:0]  load_addr,
    input  logic [35:0] load_data,
    output logic [15:0] user_out,
    output logic [8:0]  pc,
    output logic        stack_ovf,
    output logic        stack_unf
);
    localparam int unsigned LVL_W = (STACK_DEPTH == 0) ? 1 : $clog2(STACK_DEPTH + 1);

    seq_state_t st_q;
    seq_state_t st_d;

    logic [WORD_W-1:0] ir_word;
    logic [TEST_W-1:0] tests_c;
    logic              cond;
    logic [ADDR_W-1:0] stk_top;
    logic              stk_full;
    logic              stk_empty;
    logic [LVL_W-1:0]  stk_level;
    logic              push;
    logic              pop;
    logic [ADDR_W-1:0] push_data;
    logic [3:0]        opc;
    logic [ADDR_W-1:0] tgt;
    logic              started_q;
    logic [ADDR_W-1:0] cnt_q;
    logic              unused_bits;

    assign opc         = ir_word[OPC_MSB:OPC_LSB];
    assign tgt         = ir_word[TGT_MSB:TGT_LSB];
    assign unused_bits = ^{ir_word[26:25], stk_level};

    useq_progmem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
        .clk   (clk),
        .we    (load_en),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (st_d.pc),
        .rdata (ir_word)
    );

    useq_cond_sel #(.NUM(TEST_W), .MASK(TEST_REG_MASK)) u_cond (
        .clk     (clk),
        .rst     (rst),
        .raw     (test_in),
        .sel     (ir_word[SEL_MSB:SEL_LSB]),
        .pol     (ir_word[POL_BIT]),
        .tests_c (tests_c),
        .cond    (cond)
    );

    useq_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W), .LVL_W(LVL_W)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .top       (stk_top),
        .full      (stk_full),
        .empty     (stk_empty),
        .level     (stk_level)
    );

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = st_q.pc + 1'b1;
        if (!st_q.started) begin
            // First cycle out of reset: fetch word 0, execute nothing.
            st_d.started = 1'b1;
            st_d.pc      = '0;
        end else begin
            st_d.out = ir_word[OUT_W-1:0];
            st_d.pc  = st_q.pc + 1'b1;
            case (opc)
                OP_JUMP: begin
                    if (cond) st_d.pc = tgt;
                end
                OP_CALL: begin
                    if (cond) begin
                        st_d.pc = tgt;
                        if (stk_full) st_d.ovf = 1'b1;
                        else          push     = 1'b1;
                    end
                end
                OP_RET: begin
                    if (cond) begin
                        if (stk_empty) begin
                            st_d.pc  = '0;
                            st_d.unf = 1'b1;
                        end else begin
                            pop     = 1'b1;
                            st_d.pc = stk_top;
                        end
                    end
                end
                OP_LDCT: begin
                    st_d.cnt = tgt;
                end
                OP_LOOP: begin
                    if (st_q.cnt != '0) begin
                        st_d.cnt = st_q.cnt - 1'b1;
                        st_d.pc  = tgt;
                    end
                end
                OP_MWAY: begin
                    st_d.pc = tgt | {{(ADDR_W-3){1'b0}}, tests_c[2:0]};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign started_q = st_q.started;
    assign cnt_q     = st_q.cnt;
    assign user_out  = st_q.out;
    assign pc        = st_q.pc;
    assign stack_ovf = st_q.ovf;
    assign stack_unf = st_q.unf;
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
    parameter int unsigned STACK_DEPTH = 17,
    parameter int unsigned LVL_W       = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             started,
    input logic [35:0]      ir,
    input logic [15:0]      user_out,
    input logic [8:0]       pc,
    input logic [8:0]       cnt,
    input logic             ovf,
    input logic             unf,
    input logic [LVL_W-1:0] stk_level
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pc == 9'd0 && user_out == 16'd0 && !ovf && !unf && cnt == 9'd0));

    assert_out_lag_R10: assert property (@(posedge clk) disable iff (rst)
        started |=> (user_out == $past(ir[15:0])));

    assert_loop_dec_R5: assert property (@(posedge clk) disable iff (rst)
        (started && ir[35:32] == 4'd5 && cnt != 9'd0) |=> (cnt == $past(cnt) - 9'd1));

    assert_stack_bound_R6: assert property (@(posedge clk) disable iff (rst)
        32'(stk_level) <= STACK_DEPTH);

    assert_no_overflow_drop_R7: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    assert_ovf_from_call_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> ($past(ir[35:32]) == 4'd2));

    assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        unf |=> unf);
endmodule

bind useq_ctrl useq_checker #(.STACK_DEPTH(STACK_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .started   (started_q),
    .ir        (ir_word),
    .user_out  (user_out),
    .pc        (pc),
    .cnt       (cnt_q),
    .ovf       (stack_ovf),
    .unf       (stack_unf),
    .stk_level (stk_level)
);

// File: tb/useq_ctrl_bench.sv
module useq_ctrl_bench;
    localparam int unsigned DEPTH = 17;
    localparam logic [7:0]  MASK  = 8'h0F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  test_in = 8'h00;
    logic        load_en = 1'b0;
    logic [8:0]  load_addr = '0;
    logic [35:0] load_data = '0;
    logic [15:0] user_out;
    logic [8:0]  pc;
    logic        stack_ovf;
    logic        stack_unf;

    int nchecks = 0;
    int nerr    = 0;
    bit chk_on  = 0;
    bit done    = 0;
    bit phase2  = 0;

    always #5 clk = ~clk;

    useq_ctrl #(.STACK_DEPTH(DEPTH), .TEST_REG_MASK(MASK)) u_useq_ctrl (
        .clk, .rst, .test_in, .load_en, .load_addr, .load_data,
        .user_out, .pc, .stack_ovf, .stack_unf
    );

    // Behavioural reference model
    logic [35:0] prog [512];
    int          stk [$];
    logic [8:0]  m_pc, m_cnt, m_nx, m_tgt;
    logic [15:0] m_out;
    logic [7:0]  m_treg, m_tc;
    logic [3:0]  m_op, m_sel;
    logic        m_c;
    bit          m_started, m_ovf, m_unf;
    string       m_tag = "R1";

    function automatic logic [35:0] mk(logic [3:0] op, logic [3:0] sel, logic pol,
                                       logic [8:0] tgt, logic [15:0] o);
        return {op, sel, pol, 2'b00, tgt, o};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pc = '0; m_cnt = '0; m_out = '0; m_treg = '0;
            m_started = 0; m_ovf = 0; m_unf = 0;
            stk.delete();
            m_tag = "R1";
        end else begin
            m_tc   = (m_treg & MASK) | (test_in & ~MASK);
            m_treg = test_in;
            if (!m_started) begin
                m_started = 1; m_pc = '0; m_tag = "R1";
            end else begin
                m_op  = prog[m_pc][35:32];
                m_sel = prog[m_pc][31:28];
                m_tgt = prog[m_pc][24:16];
                m_out = prog[m_pc][15:0];
                m_c   = (m_sel[3] ? 1'b1 : m_tc[m_sel[2:0]]) ^ prog[m_pc][27];
                m_nx  = m_pc + 9'd1;
                m_tag = "R2";
                case (m_op)
                    4'd1: begin
                        m_tag = (!m_sel[3] && MASK[m_sel[2:0]]) ? "R3 R4" : "R3";
                        if (m_c) m_nx = m_tgt;
                    end
                    4'd2: begin
                        m_tag = "R6";
                        if (m_c) begin
                            m_nx = m_tgt;
                            if (stk.size() < int'(DEPTH)) stk.push_back(int'(m_pc + 9'd1));
                            else begin m_ovf = 1; m_tag = "R7"; end
                        end
                    end
                    4'd3: begin
                        m_tag = "R6";
                        if (m_c) begin
                            if (stk.size() == 0) begin m_nx = '0; m_unf = 1; m_tag = "R8"; end
                            else m_nx = 9'(stk.pop_back());
                        end
                    end
                    4'd4: begin m_tag = "R5"; m_cnt = m_tgt; end
                    4'd5: begin
                        m_tag = "R5";
                        if (m_cnt != 0) begin m_cnt = m_cnt - 9'd1; m_nx = m_tgt; end
                    end
                    4'd6: begin m_tag = "R9 R4"; m_nx = m_tgt | {6'd0, m_tc[2:0]}; end
                    default: ;
                endcase
                m_pc = m_nx;
            end
        end
        if (load_en) prog[load_addr] = load_data;
    end

    task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s%s: actual %h expected %h at %0t",
                     phase2 ? "R11 " : "", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            chk({m_tag, " pc"}, 36'(pc), 36'(m_pc));
            chk("R10 user_out", 36'(user_out), 36'(m_out));
            chk("R7 overflow flag", 36'(stack_ovf), 36'(m_ovf));
            chk("R8 underflow flag", 36'(stack_unf), 36'(m_unf));
        end
    end

    function automatic logic [35:0] prog1(int a);
        logic [15:0] o;
        o = 16'hA000 | 16'(a);
        case (a)
            0:   return mk(4'd0, 4'd8, 1'b0, 9'd0, o);
            1:   return mk(4'd4, 4'd8, 1'b0, 9'd3, o);
            2:   return mk(4'd0, 4'd8, 1'b0, 9'd0, o);
            3:   return mk(4'd5, 4'd8, 1'b0, 9'd2, o);
            4:   return mk(4'd1, 4'd0, 1'b0, 9'd8, o);
            5:   return mk(4'd1, 4'd5, 1'b1, 9'd10, o);
            6:   return mk(4'd6, 4'd8, 1'b0, 9'd16, o);
            7:   return mk(4'd9, 4'd8, 1'b0, 9'd0, o);
            8:   return mk(4'd2, 4'd2, 1'b0, 9'd30, o);
            9:   return mk(4'd1, 4'd4, 1'b0, 9'd510, o);
            10:  return mk(4'd2, 4'd12, 1'b0, 9'd30, o);
            11:  return mk(4'd1, 4'd8, 1'b0, 9'd6, o);
            30:  return mk(4'd0, 4'd8, 1'b0, 9'd0, o);
            31:  return mk(4'd3, 4'd1, 1'b0, 9'd0, o);
            32:  return mk(4'd3, 4'd8, 1'b0, 9'd0, o);
            40:  return mk(4'd4, 4'd8, 1'b0, 9'd20, o);
            41:  return mk(4'd2, 4'd8, 1'b0, 9'd43, o);
            42:  return mk(4'd3, 4'd8, 1'b0, 9'd0, o);
            43:  return mk(4'd5, 4'd8, 1'b0, 9'd41, o);
            44:  return mk(4'd3, 4'd8, 1'b0, 9'd0, o);
            510: return mk(4'd0, 4'd8, 1'b0, 9'd0, o);
            511: return mk(4'd15, 4'd8, 1'b0, 9'd0, o);
            default: begin
                if (a >= 16 && a <= 24) begin
                    if (a % 2 == 0 || a == 24) return mk(4'd1, 4'd9, 1'b0, 9'd40, o);
                    return mk(4'd1, 4'(a - 16), 1'b0, 9'd0, o);
                end
                return mk(4'd1, 4'd8, 1'b0, 9'd0, o);
            end
        endcase
    endfunction

    function automatic logic [35:0] prog2(int a);
        logic [15:0] o;
        o = 16'h5000 ^ 16'(a * 16'h0111);
        if (a == 0) return mk(4'd6, 4'd8, 1'b0, 9'd200, o);
        if (a >= 200 && a <= 207) return mk(4'd0, 4'd8, 1'b0, 9'd0, o);
        if (a == 208) return mk(4'd1, 4'd7, 1'b1, 9'd0, o);
        return mk(4'd1, 4'd8, 1'b0, 9'd0, o);
    endfunction

    task automatic load_all(bit second);
        for (int a = 0; a < 512; a++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = 9'(a);
            load_data = second ? prog2(a) : prog1(a);
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run(int cycles);
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            test_in = lfsr[7:0] ^ lfsr[15:8];
        end
    endtask

    initial begin
        @(posedge clk);
        #1 chk_on = 1;
        // R11: program written through the load port under reset
        load_all(0);
        @(negedge clk);
        rst = 1'b0;
        run(3000);
        // R1 and R11: reset again, replace the program, run it
        @(negedge clk);
        rst = 1'b1;
        phase2 = 1;
        load_all(1);
        @(negedge clk);
        rst = 1'b0;
        run(600);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            nerr++;
            nchecks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end
endmodule